// File: doc/BRIEF.md
# Parallel Byte Input Port

This block sits between a byte-wide input device and a simple processor bus. The device presents a byte together with a valid strobe. The block keeps that byte in a one-word holding register and sets a full flag. The processor polls the flag at one bus location and collects the byte at a neighbouring location. Collecting the byte empties the register, which lets the device deliver its next byte.

The port answers only when the upper address bits match a fixed base. The lowest address bit chooses between the status word and the data word. A read is accepted when master-ready, read direction and an address match are all present. The port then raises slave-ready for one clock and drives the shared data lines during that clock only. At all other times the data lines are left at high impedance.

Two state machines do the work. The bus machine has the states BUS_IDLE, BUS_SERVE and BUS_HOLD:
- BUS_IDLE goes to BUS_SERVE when a read is accepted.
- BUS_SERVE goes to BUS_HOLD if master-ready is still high, and otherwise returns to BUS_IDLE.
- BUS_HOLD goes back to BUS_IDLE once master-ready falls.

The buffer machine has the states BUF_EMPTY and BUF_FULL:
- BUF_EMPTY goes to BUF_FULL on a device strobe.
- BUF_FULL goes back to BUF_EMPTY when a data read completes.

Top module: `byte_in_port`

## Requirements
- R1: A synchronous active-high reset clears the full flag and the holding register to zero. It also puts the bus machine in BUS_IDLE, so slave-ready is low and the data lines are not driven.
- R2: The port responds only when address bits [ADDR_W-1:1] equal bits [ADDR_W-1:1] of BASE_ADDR. An access to any other address gives no slave-ready and no drive.
- R3: A read is accepted only on a clock edge where bus_mrdy and bus_rd are both 1 and the address matches. With bus_rd at 0, or bus_mrdy at 0, there is no response.
- R4: slave-ready is high for exactly the one clock that follows the accepting edge. If master-ready stays high longer, no further pulse appears until master-ready has dropped.
- R5: The data lines (bus_data) are driven, and bus_drive is 1, only in the slave-ready clock. Otherwise they are high impedance.
- R6: When address bit 0 is 1 (a status read), bus_data bit 0 carries the full flag and all other bits are 0.
- R7: When address bit 0 is 0 (a data read), bus_data carries the byte in the holding register.
- R8: A device strobe captures dev_data and sets the full flag only when the register is empty. A strobe that arrives while the register is full, including on the edge that ends a data read, is ignored and the stored byte is kept.
- R9: The full flag clears on the edge that ends the slave-ready clock of a data read. A status read leaves the flag unchanged.
- R10: A strobe on any edge after a data read has completed is captured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read direction (1 = read) |
| bus_mrdy | input | 1 | Master-ready from the processor |
| bus_data | inout | DATA_W | Shared three-state data lines |
| bus_srdy | output | 1 | Slave-ready, one clock per accepted read |
| bus_drive | output | 1 | High while the port drives bus_data |
| dev_data | input | DATA_W | Byte from the input device |
| dev_valid | input | 1 | Device strobe marking dev_data as valid |

## Verification
A wrong full flag shows at the next status read. It also shows at the next strobe: a strobe that should have been dropped overwrites the byte, or a strobe that should have been captured is lost. Either error appears within the next data read. A bus machine stuck in the wrong state shows in the very clock after an accepted read. It appears as a missing pulse, a double pulse, or data lines driven outside the slave-ready clock. The bench therefore samples slave-ready, the drive enable and the returned word in every clock around each access.

// File: rtl/bip_pkg.sv
package bip_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SERVE = 2'd1,
        BUS_HOLD  = 2'd2
    } bus_state_e;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

    typedef enum logic {
        SEL_DATA   = 1'b0,
        SEL_STATUS = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/bip_addr_decode.sv
module bip_addr_decode
    import bip_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output rd_sel_e           sel
);
    localparam int TAG_W = ADDR_W - 1;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:1];

    always_comb begin
        hit = (addr[ADDR_W-1:1] == BASE_TAG);
        sel = addr[0] ? SEL_STATUS : SEL_DATA;
    end
endmodule

// File: rtl/bip_bus_fsm.sv
module bip_bus_fsm
    import bip_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    mrdy,
    input  rd_sel_e sel_in,
    output logic    srdy,
    output logic    drive,
    output rd_sel_e sel_q,
    output logic    data_taken
);
    bus_state_e state_q, state_d;
    logic       accept;

    assign accept = (state_q == BUS_IDLE) && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUS_IDLE;
            sel_q   <= SEL_DATA;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sel_q <= sel_in;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (req) state_d = BUS_SERVE;
            BUS_SERVE: state_d = mrdy ? BUS_HOLD : BUS_IDLE;
            BUS_HOLD:  if (!mrdy) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        srdy       = 1'b0;
        drive      = 1'b0;
        data_taken = 1'b0;
        unique case (state_q)
            BUS_SERVE: begin
                srdy       = 1'b1;
                drive      = 1'b1;
                data_taken = (sel_q == SEL_DATA);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bip_buffer.sv
module bip_buffer
    import bip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] din,
    input  logic              taken,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    buf_state_e        state_q, state_d;
    logic              capture;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BUF_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                word_q <= din;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            BUF_EMPTY: if (strobe) begin
                capture = 1'b1;
                state_d = BUF_FULL;
            end
            BUF_FULL:  if (taken) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
    end

    always_comb begin
        full = (state_q == BUF_FULL);
        word = word_q;
    end
endmodule

// File: rtl/byte_in_port.sv
module byte_in_port
    import bip_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_mrdy,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              bus_srdy,
    output logic              bus_drive,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_valid
);
    localparam int PAD_W = DATA_W - 1;

    logic              hit;
    rd_sel_e           sel_in;
    rd_sel_e           sel_q;
    logic              req;
    logic              data_taken;
    logic              buf_full;
    logic [DATA_W-1:0] buf_word;
    logic [DATA_W-1:0] rd_word;

    bip_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel_in)
    );

    assign req = hit && bus_rd && bus_mrdy;

    bip_bus_fsm u_bus (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .mrdy       (bus_mrdy),
        .sel_in     (sel_in),
        .srdy       (bus_srdy),
        .drive      (bus_drive),
        .sel_q      (sel_q),
        .data_taken (data_taken)
    );

    bip_buffer #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .strobe (dev_valid),
        .din    (dev_data),
        .taken  (data_taken),
        .full   (buf_full),
        .word   (buf_word)
    );

    always_comb begin
        if (sel_q == SEL_STATUS) begin
            rd_word = {{PAD_W{1'b0}}, buf_full};
        end else begin
            rd_word = buf_word;
        end
    end

    assign bus_data = bus_drive ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/byte_in_port_chk.sv
module byte_in_port_chk #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_mrdy,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_srdy,
    input logic              bus_drive,
    input logic              dev_valid,
    input logic              buf_full
);
    logic addr_ok;
    assign addr_ok = (bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!bus_srdy && !bus_drive && !buf_full));

    assert_decode_only_R2: assert property (@(posedge clk) disable iff (rst)
        bus_srdy |-> $past(addr_ok));

    assert_needs_mrdy_rd_R3: assert property (@(posedge clk) disable iff (rst)
        bus_srdy |-> $past(bus_mrdy && bus_rd));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        bus_srdy |=> !bus_srdy);

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (bus_srdy && $past(bus_mrdy && bus_rd && addr_ok)));

    assert_status_format_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_drive && $past(bus_addr[0])) |-> (bus_data[DATA_W-1:1] == '0));

    assert_capture_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> $past(dev_valid));

    assert_full_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !bus_srdy) |=> buf_full);
endmodule

bind byte_in_port byte_in_port_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_mrdy  (bus_mrdy),
    .bus_data  (bus_data),
    .bus_srdy  (bus_srdy),
    .bus_drive (bus_drive),
    .dev_valid (dev_valid),
    .buf_full  (buf_full)
);

// File: tb/test_byte_in_port.sv
`timescale 1ns/1ps
module test_byte_in_port;
    localparam int              DW   = 8;
    localparam int              AW   = 8;
    localparam logic [AW-1:0]   BASE = 8'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_mrdy = 1'b0;
    wire  [DW-1:0] bus_data;
    logic          bus_srdy;
    logic          bus_drive;
    logic [DW-1:0] dev_data = '0;
    logic          dev_valid = 1'b0;

    int            n_run = 0;
    int            n_fail = 0;
    bit            exp_full = 1'b0;
    logic [DW-1:0] exp_buf = '0;

    always #2.5 clk = ~clk;

    byte_in_port #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) i_byte_in_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_mrdy(bus_mrdy), .bus_data(bus_data), .bus_srdy(bus_srdy),
        .bus_drive(bus_drive), .dev_data(dev_data), .dev_valid(dev_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] status_word(input bit f);
        return {{(DW-1){1'b0}}, f};
    endfunction

    function automatic bit addr_hits(input logic [AW-1:0] a);
        return a[AW-1:1] == BASE[AW-1:1];
    endfunction

    task automatic check_quiet(input string tag);
        check(bus_srdy == 1'b0, {tag, " srdy low"}, 32'(bus_srdy), 0);
        check(bus_drive == 1'b0, {tag, " not driving"}, 32'(bus_drive), 0);
    endtask

    task automatic strobe(input logic [DW-1:0] d);
        dev_data  = d;
        dev_valid = 1'b1;
        @(posedge clk); #1;
        dev_valid = 1'b0;
        if (!exp_full) begin
            exp_full = 1'b1;
            exp_buf  = d;
        end
    endtask

    // one bus access; hold = clocks master-ready stays high after the accepting edge
    task automatic access(input logic [AW-1:0] a, input bit rd, input bit mrdy,
                          input int hold, input bit str, input logic [DW-1:0] sd);
        bit            hit;
        bit            cap;
        logic [DW-1:0] expv;
        hit      = addr_hits(a) && rd && mrdy;
        expv     = a[0] ? status_word(exp_full) : exp_buf;
        bus_addr = a;
        bus_rd   = rd;
        bus_mrdy = mrdy;
        @(posedge clk); #1;
        if (hit) begin
            check(bus_srdy == 1'b1, "R4 srdy after accept", 32'(bus_srdy), 1);
            check(bus_drive == 1'b1, "R5 drive in srdy clock", 32'(bus_drive), 1);
            if (a[0]) check(bus_data === expv, "R6 status word", 32'(bus_data), 32'(expv));
            else      check(bus_data === expv, "R7 data word", 32'(bus_data), 32'(expv));
        end else if (!addr_hits(a)) begin
            check_quiet("R2 foreign address");
        end else begin
            check_quiet("R3 no mrdy or no rd");
        end
        if (str) begin
            dev_data  = sd;
            dev_valid = 1'b1;
        end
        if (hold <= 1) bus_mrdy = 1'b0;
        @(posedge clk); #1;
        dev_valid = 1'b0;
        cap = str && !exp_full;
        if (hit && !a[0]) exp_full = 1'b0;
        if (cap) begin
            exp_full = 1'b1;
            exp_buf  = sd;
        end
        if (hold > 1) begin
            check_quiet("R4 no repeat while mrdy held");
            for (int i = 2; i < hold; i++) begin
                @(posedge clk); #1;
                check_quiet("R4 still held");
            end
            bus_mrdy = 1'b0;
            @(posedge clk); #1;
        end
        check_quiet("R5 released");
        bus_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        int            op;
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_quiet("R1 after reset");
        access(BASE | 8'h01, 1, 1, 1, 0, 0);          // R1 full flag clear
        access(BASE, 1, 1, 1, 0, 0);                  // R1 register zero

        strobe(8'hA5);
        access(BASE | 8'h01, 1, 1, 1, 0, 0);          // R6 flag set
        access(BASE | 8'h01, 1, 1, 1, 0, 0);          // R9 status read keeps it
        access(BASE, 1, 1, 1, 0, 0);                  // R7
        access(BASE | 8'h01, 1, 1, 1, 0, 0);          // R9 cleared

        strobe(8'h11);
        strobe(8'h22);                                // R8 ignored
        access(BASE, 1, 1, 1, 0, 0);

        strobe(8'h33);
        access(BASE, 1, 1, 1, 1, 8'h44);              // R8 strobe on ending edge dropped
        access(BASE | 8'h01, 1, 1, 1, 0, 0);
        strobe(8'h55);                                // R10
        access(BASE, 1, 1, 1, 0, 0);
        check(exp_buf == 8'h55, "R10 capture after read", 32'(exp_buf), 32'h55);

        access(BASE ^ 8'h10, 1, 1, 1, 0, 0);          // R2
        access(BASE ^ 8'h80, 1, 1, 1, 0, 0);          // R2
        access(BASE, 0, 1, 1, 0, 0);                  // R3 write direction
        access(BASE | 8'h01, 1, 0, 1, 0, 0);          // R3 no mrdy
        strobe(8'h66);
        access(BASE, 1, 1, 4, 0, 0);                  // R4 long master-ready

        for (int n = 0; n < 400; n++) begin
            op = int'($urandom_range(0, 5));
            a  = ($urandom_range(0, 3) == 0) ? AW'($urandom) : (BASE | AW'($urandom_range(0, 1)));
            case (op)
                0, 1: strobe(DW'($urandom));
                2:    access(a, 1, 1, 1, 0, 0);
                3:    access(a, 1, 1, int'($urandom_range(1, 3)), $urandom_range(0, 1) == 1, DW'($urandom));
                4:    access(a, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1, 0, 0);
                default: begin
                    @(posedge clk); #1;
                    check_quiet("R5 idle");
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule